// File: doc/BRIEF.md
# Core Reset Sequencer with Clock Strap Capture

This block turns an active-low board reset into the internal core reset of a peripheral device. While the board reset is held, it keeps capturing two strap pins. One strap picks which reference clock input is used. The other strap gives the frequency of that input. The values captured last are frozen when the synchronized reset release arrives, and they drive the clock configuration that follows.

Release goes through a two-flop synchronizer. The core reset is then stretched by a fixed number of system clocks. During that window a pin-hold enable keeps the functional pins in their reset state. When the core reset lifts, a device-ready interrupt is raised toward the host. It stays up until the host acknowledges it. A strap combination that chooses the alternate input but carries the reserved frequency code raises a configuration-error flag.

Top module: `rst_seq_strap`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n` is 0, `pin_hold` is 1 and `ready_irq` is 0. This holds asynchronously, without waiting for a clock edge.
- R2: After `ext_rst_n` rises, `core_rst_n` stays 0 through the 17th rising edge of `clk_sys`. It becomes 1 at the 18th rising edge: two synchronizer stages, then 16 counted cycles.
- R3: `pin_hold` is 1 exactly while `core_rst_n` is 0.
- R4: `clk_sel_alt` gives the clock-source strap as captured during reset. A value of 0 selects the 38.4 MHz input and a value of 1 selects the 19.2 MHz input.
- R5: With the source strap captured as 1, `cfg_err` is 1 when the frequency strap was captured as 0 (the reserved code). It is 0 when the frequency strap was captured as 1 (19.2 MHz).
- R6: With the source strap captured as 0, the frequency strap has no effect: `cfg_err` is 0 and `clk_sel_alt` is 0 for either frequency strap level.
- R7: Strap changes made after the core reset has lifted do not change `clk_sel_alt` or `cfg_err`.
- R8: `ready_irq` rises on the same clock edge on which `core_rst_n` rises.
- R9: `ready_irq` stays 1 until `irq_ack` is sampled high on a rising edge, and it is 0 after that edge. It does not set again until a new reset sequence completes.
- R10: Asserting `ext_rst_n` low during the stretch window restarts the whole sequence. The full R2 count applies again after the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assertion |
| strap_src | input | 1 | Clock-source strap pin |
| strap_freq | input | 1 | Frequency-select strap pin |
| irq_ack | input | 1 | Host acknowledge of the ready interrupt |
| core_rst_n | output | 1 | Internal core reset, active low |
| pin_hold | output | 1 | Keeps functional pins in reset state |
| clk_sel_alt | output | 1 | Captured clock source (1 = 19.2 MHz input) |
| cfg_err | output | 1 | Reserved frequency code captured with alternate source |
| ready_irq | output | 1 | Device-ready interrupt |

## Verification
The bench sweeps all four strap combinations through full reset sequences. The sweep tells the 38.4 MHz source apart from the 19.2 MHz source, and it separates the reserved frequency code from the valid one in the only case where that code matters. After each release the straps are inverted, which shows whether anything is still being captured. The release is timed edge by edge, so a synchronizer or counter that is one cycle short or long is caught. A reset that interrupts the stretch window, and acknowledges given after different delays, separate a correct restart and interrupt hold from early clearing or re-arming.

// File: rtl/rst_seq_strap.sv
module rst_seq_strap #(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_sys,
  input  logic ext_rst_n,
  input  logic strap_src,
  input  logic strap_freq,
  input  logic irq_ack,
  output logic core_rst_n,
  output logic pin_hold,
  output logic clk_sel_alt,
  output logic cfg_err,
  output logic ready_irq
);

  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   src_q, freq_q;
  logic                   rel_sync;

  assign rel_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_sys or negedge ext_rst_n)
    if (!ext_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk_sys or negedge ext_rst_n)
    if (!ext_rst_n) begin
      cnt_q      <= '0;
      core_rst_n <= 1'b0;
      ready_irq  <= 1'b0;
    end else if (!core_rst_n) begin
      if (rel_sync) begin
        if (cnt_q == LAST) begin
          core_rst_n <= 1'b1;
          ready_irq  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (irq_ack) begin
      ready_irq <= 1'b0;
    end

  always_ff @(posedge clk_sys)
    if (!rel_sync) begin
      src_q  <= strap_src;
      freq_q <= strap_freq;
    end

  assign pin_hold    = ~core_rst_n;
  assign clk_sel_alt = src_q;
  assign cfg_err     = src_q & ~freq_q;

  AST_RST_FORCES: assert property (@(posedge clk_sys)
    !ext_rst_n |-> (!core_rst_n && !ready_irq)); // R1
  AST_REL_AFTER_SYNC: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> $past(rel_sync)); // R2
  AST_CORE_STAYS: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    core_rst_n |=> core_rst_n); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    core_rst_n |-> $stable({clk_sel_alt, cfg_err})); // R7
  AST_ERR_NEEDS_ALT: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    cfg_err |-> clk_sel_alt); // R6
  AST_IRQ_WITH_REL: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    $rose(ready_irq) |-> $rose(core_rst_n)); // R8
  AST_IRQ_HOLDS: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    (ready_irq && !irq_ack) |=> ready_irq); // R9
  AST_IRQ_NO_REARM: assert property (@(posedge clk_sys) disable iff (!ext_rst_n)
    (core_rst_n && !ready_irq) |=> !ready_irq); // R9

endmodule

// File: tb/test_rst_seq_strap.sv
module test_rst_seq_strap;
  logic clk_sys = 1'b0;
  logic ext_rst_n = 1'b0;
  logic strap_src = 1'b0, strap_freq = 1'b0, irq_ack = 1'b0;
  logic core_rst_n, pin_hold, clk_sel_alt, cfg_err, ready_irq;
  int checks = 0, fails = 0;

  always #10 clk_sys = ~clk_sys;

  rst_seq_strap i_rst_seq_strap (
    .clk_sys(clk_sys), .ext_rst_n(ext_rst_n), .strap_src(strap_src),
    .strap_freq(strap_freq), .irq_ack(irq_ack), .core_rst_n(core_rst_n),
    .pin_hold(pin_hold), .clk_sel_alt(clk_sel_alt), .cfg_err(cfg_err),
    .ready_irq(ready_irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_sys);
    #1;
  endtask

  task automatic hold_reset(input logic s, input logic f);
    @(negedge clk_sys);
    ext_rst_n = 1'b0; strap_src = s; strap_freq = f;
    #3;
    chk("R1", {5'b0, core_rst_n, pin_hold, ready_irq}, 8'b0000_0010);
    cyc(4);
    chk("R1", {5'b0, core_rst_n, pin_hold, ready_irq}, 8'b0000_0010);
  endtask

  task automatic release_and_time;
    int early;
    @(negedge clk_sys);
    ext_rst_n = 1'b1;
    early = 0;
    for (int k = 1; k <= 17; k++) begin
      @(posedge clk_sys); #1;
      if (core_rst_n !== 1'b0 || pin_hold !== 1'b1 || ready_irq !== 1'b0) early++;
    end
    chk("R2", 8'(early), 8'd0);
    @(posedge clk_sys); #1;
    chk("R2", {7'b0, core_rst_n}, 8'd1);
    chk("R3", {7'b0, pin_hold}, 8'd0);
    chk("R8", {7'b0, ready_irq}, 8'd1);
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      logic s, f;
      s = c[1]; f = c[0];
      hold_reset(s, f);
      release_and_time();
      chk("R4", {7'b0, clk_sel_alt}, {7'b0, s});
      if (s) chk("R5", {7'b0, cfg_err}, {7'b0, ~f});
      else   chk("R6", {6'b0, clk_sel_alt, cfg_err}, 8'd0);
      @(negedge clk_sys);
      strap_src = ~s; strap_freq = ~f;
      cyc(4);
      chk("R7", {6'b0, clk_sel_alt, cfg_err}, {6'b0, s, s & ~f});
      cyc(c * 3 + 1);
      chk("R9", {7'b0, ready_irq}, 8'd1);
      @(negedge clk_sys); irq_ack = 1'b1;
      @(posedge clk_sys); #1;
      chk("R9", {7'b0, ready_irq}, 8'd0);
      @(negedge clk_sys); irq_ack = 1'b0;
      cyc(6);
      chk("R9", {7'b0, ready_irq}, 8'd0);
      chk("R3", {6'b0, core_rst_n, pin_hold}, 8'b10);
    end

    hold_reset(1'b1, 1'b1);
    @(negedge clk_sys); ext_rst_n = 1'b1;
    cyc(10);
    chk("R10", {7'b0, core_rst_n}, 8'd0);
    hold_reset(1'b1, 1'b0);
    release_and_time();
    chk("R10", {6'b0, clk_sel_alt, cfg_err}, 8'b11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule